// File: doc/BRIEF.md
# Bus Clock Prescaler Enable Generator

This block turns one system clock into three clock-enable streams: one for a high-speed bus and one for each of two peripheral buses. No clock is gated or divided physically; every consumer stays on the system clock and qualifies its registers with the matching enable. The high-speed enable is the system clock divided by a power of two. Each peripheral enable is a further power-of-two division, and its counter steps only on high-speed enable cycles, so the peripheral ratio multiplies the high-speed ratio.

The divide ratios come from three small coded fields written through a simple write port. A combinational readback port returns the stored code of the selected field and the overall divide ratio that code gives against the system clock. A new ratio takes effect at the end of the division period that is in progress, so no period is cut short or stretched.

Top module: `bcp_prescaler_top`

## Requirements
- R1: After reset all three fields read back 0, every readback ratio is 1, and `hbus_en` and both `pbus_en` bits are high on every cycle.
- R2: The high-speed field is 4 bits. Codes 0 to 7 divide by 1. Codes 8, 9, 10, 11, 12, 13, 14 and 15 divide by 2, 4, 8, 16, 64, 128, 256 and 512; no code gives 32.
- R3: Each peripheral field is 3 bits (the low 3 bits of `cfg_wdata`). Codes 0 to 3 divide by 1. Codes 4, 5, 6 and 7 divide by 2, 4, 8 and 16.
- R4: A peripheral divider advances only on cycles where `hbus_en` is high, so its enable period in system clock cycles equals the high-speed ratio times the peripheral ratio, and `pbus_en[i]` is never high while `hbus_en` is low.
- R5: The two peripheral fields are independent; writing one changes neither the code nor the output period of the other.
- R6: Each enable is high for exactly one system clock cycle per divided period; at divide by 1 it stays high.
- R7: A written ratio takes effect only at the next terminal count of its divider; the period in progress at the write completes at the old length.
- R8: `cfg_rfield` returns the code last written to the selected field and `cfg_rratio` the overall ratio that code gives (high-speed ratio for address 0, high-speed ratio times own ratio for a peripheral), both at once after the write, even while the new ratio waits for the terminal count.
- R9: Write address 0 selects the high-speed field, address 1 peripheral field 0, address 2 peripheral field 1; a write to address 3 changes no field and no output, and address 3 reads back 0 in both readback outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_waddr | input | 2 | Field select for writes |
| cfg_wdata | input | 4 | Code to write |
| cfg_raddr | input | 2 | Field select for readback |
| cfg_rfield | output | 4 | Stored code of the selected field |
| cfg_rratio | output | 14 | Overall divide ratio of the selected field |
| hbus_en | output | 1 | High-speed bus clock enable |
| pbus_en | output | 2 | Peripheral bus clock enables, bit i for field i |

## Verification
On every cycle the assertions check that a peripheral enable only fires together with the high-speed enable, that a divider counter holds on cycles without an advance tick and never passes its terminal count, that a pulse at a ratio above one is followed by a low cycle, and that a write lands in the addressed field and nowhere else. The code-to-ratio mapping, the product of cascaded ratios, the separation of the two peripheral fields and the deferral of a new ratio to the next terminal count are only visible through the bench's scenarios, which measure periods between enable pulses and read fields back before and after a pending change.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

   // Field widths are fixed by the code tables below.
   localparam int HS_FW     = 4;
   localparam int PB_FW     = 3;
   // Shift amounts are log2 of the divide ratio.
   localparam int SH_W      = 4;
   localparam int HS_MAX_SH = 9;
   localparam int PB_MAX_SH = 4;

   typedef logic [SH_W-1:0] shift_t;

   // High-speed code: top bit clear means no division. With the top bit set,
   // the lower half steps 1..4 and the upper half jumps past 5, giving 6..9.
   function automatic shift_t hs_code_to_shift(input logic [HS_FW-1:0] code);
      shift_t low;
      low = {1'b0, code[2:0]};
      if (!code[3])
         return '0;
      else if (!code[2])
         return low + shift_t'(1);
      else
         return low + shift_t'(2);
   endfunction

   // Peripheral code: top bit clear means no division, otherwise 1..4.
   function automatic shift_t pb_code_to_shift(input logic [PB_FW-1:0] code);
      if (!code[2])
         return '0;
      else
         return {2'b00, code[1:0]} + shift_t'(1);
   endfunction

endpackage

// File: rtl/bcp_div_stage.sv
module bcp_div_stage
   import bcp_pkg::*;
#(
   parameter int CNT_W = 9
)(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick_in,
   input  shift_t req_sh,
   output logic   en_out
);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("bcp_div_stage: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] ones;
   shift_t           act_sh;
   logic             term_hit;

   assign ones     = '1;
   assign term     = ~(ones << act_sh);
   assign term_hit = (cnt == term);
   assign en_out   = tick_in & term_hit;

   // The active ratio is reloaded only at the terminal count.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         act_sh <= '0;
      end else if (tick_in) begin
         if (term_hit) begin
            cnt    <= '0;
            act_sh <= req_sh;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_in |=> $stable(cnt));

   assert_cnt_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term);

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_out && act_sh != '0 && req_sh != '0) |=> !en_out);

endmodule

// File: rtl/bcp_cfg_regs.sv
module bcp_cfg_regs
   import bcp_pkg::*;
#(
   parameter int NUM_PB  = 2,
   parameter int AW      = 2,
   parameter int RATIO_W = 14
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [AW-1:0]               waddr,
   input  logic [HS_FW-1:0]            wdata,
   input  logic [AW-1:0]               raddr,
   output shift_t                      hs_sh,
   output shift_t [NUM_PB-1:0]         pb_sh,
   output logic [HS_FW-1:0]            rfield,
   output logic [RATIO_W-1:0]          rratio
);

   logic [HS_FW-1:0]             hs_code;
   logic [NUM_PB-1:0][PB_FW-1:0] pb_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hs_code <= '0;
      else if (we && waddr == '0)
         hs_code <= wdata;
   end

   assign hs_sh = hs_code_to_shift(hs_code);

   generate
      for (genvar i = 0; i < NUM_PB; i++) begin : g_pb_field
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pb_code[i] <= '0;
            else if (we && waddr == AW'(i + 1))
               pb_code[i] <= wdata[PB_FW-1:0];
         end

         assign pb_sh[i] = pb_code_to_shift(pb_code[i]);

         assert_pb_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr == AW'(i + 1)) |=> pb_code[i] == $past(wdata[PB_FW-1:0]));

         assert_pb_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == AW'(i + 1)) |=> $stable(pb_code[i]));
      end
   endgenerate

   // Readback reflects the stored codes, not the ratios currently counting.
   always_comb begin
      logic [SH_W:0] tot;
      rfield = '0;
      rratio = '0;
      tot    = '0;
      if (raddr == '0) begin
         rfield = hs_code;
         rratio = RATIO_W'(1) << hs_sh;
      end
      for (int i = 0; i < NUM_PB; i++) begin
         if (raddr == AW'(i + 1)) begin
            tot    = {1'b0, hs_sh} + {1'b0, pb_sh[i]};
            rfield = {{(HS_FW-PB_FW){1'b0}}, pb_code[i]};
            rratio = RATIO_W'(1) << tot;
         end
      end
   end

   assert_hs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == '0) |=> hs_code == $past(wdata));

   assert_hs_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == '0) |=> $stable(hs_code));

endmodule

// File: rtl/bcp_prescaler_top.sv
module bcp_prescaler_top
   import bcp_pkg::*;
#(
   parameter int NUM_PB   = 2,
   parameter int AW       = 2,
   parameter int HS_CNT_W = 9,
   parameter int PB_CNT_W = 4,
   parameter int RATIO_W  = 14
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [AW-1:0]      cfg_waddr,
   input  logic [HS_FW-1:0]   cfg_wdata,
   input  logic [AW-1:0]      cfg_raddr,
   output logic [HS_FW-1:0]   cfg_rfield,
   output logic [RATIO_W-1:0] cfg_rratio,
   output logic               hbus_en,
   output logic [NUM_PB-1:0]  pbus_en
);

   localparam int MIN_RATIO_W = HS_MAX_SH + PB_MAX_SH + 1;

   generate
      if (HS_CNT_W < HS_MAX_SH) begin : g_chk_hs
         $error("bcp_prescaler_top: HS_CNT_W too small for the largest code");
      end
      if (PB_CNT_W < PB_MAX_SH) begin : g_chk_pb
         $error("bcp_prescaler_top: PB_CNT_W too small for the largest code");
      end
      if ((1 << AW) < NUM_PB + 1) begin : g_chk_aw
         $error("bcp_prescaler_top: AW cannot address every field");
      end
      if (RATIO_W < MIN_RATIO_W) begin : g_chk_rw
         $error("bcp_prescaler_top: RATIO_W cannot hold the largest ratio");
      end
   endgenerate

   shift_t              hs_sh;
   shift_t [NUM_PB-1:0] pb_sh;

   bcp_cfg_regs #(
      .NUM_PB  (NUM_PB),
      .AW      (AW),
      .RATIO_W (RATIO_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .waddr  (cfg_waddr),
      .wdata  (cfg_wdata),
      .raddr  (cfg_raddr),
      .hs_sh  (hs_sh),
      .pb_sh  (pb_sh),
      .rfield (cfg_rfield),
      .rratio (cfg_rratio)
   );

   bcp_div_stage #(
      .CNT_W (HS_CNT_W)
   ) u_hs_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_in (1'b1),
      .req_sh  (hs_sh),
      .en_out  (hbus_en)
   );

   generate
      for (genvar i = 0; i < NUM_PB; i++) begin : g_pb_div
         bcp_div_stage #(
            .CNT_W (PB_CNT_W)
         ) u_pb_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_in (hbus_en),
            .req_sh  (pb_sh[i]),
            .en_out  (pbus_en[i])
         );

         assert_pb_inside_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pbus_en[i] |-> hbus_en);
      end
   endgenerate

endmodule

// File: tb/bcp_prescaler_top_tb.sv
module bcp_prescaler_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 8;
   localparam int WD_LIMIT   = 150000;

   // hs code, pb0 code, pb1 code, expected periods of hbus, pbus0, pbus1
   localparam int VEC [NVEC][6] = '{
      '{ 3, 2, 1,   1,    1,    1},
      '{ 8, 4, 7,   2,    4,   32},
      '{ 9, 5, 6,   4,   16,   32},
      '{12, 4, 0,  64,  128,   64},
      '{15, 4, 5, 512, 1024, 2048},
      '{11, 7, 4,  16,  256,   32},
      '{14, 0, 6, 256,  256, 2048},
      '{10, 3, 5,   8,    8,   32}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_waddr = '0;
   logic [3:0]  cfg_wdata = '0;
   logic [1:0]  cfg_raddr = '0;
   logic [3:0]  cfg_rfield;
   logic [13:0] cfg_rratio;
   logic        hbus_en;
   logic [1:0]  pbus_en;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int hi_cnt   [3] = '{0, 0, 0};
   int last_hi  [3] = '{0, 0, 0};
   int gap_last [3] = '{0, 0, 0};
   int pb_viol  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcp_prescaler_top u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_waddr  (cfg_waddr),
      .cfg_wdata  (cfg_wdata),
      .cfg_raddr  (cfg_raddr),
      .cfg_rfield (cfg_rfield),
      .cfg_rratio (cfg_rratio),
      .hbus_en    (hbus_en),
      .pbus_en    (pbus_en)
   );

   // Pulse monitor: samples away from the active edge.
   always @(negedge clk) begin
      logic [2:0] en;
      cyc = cyc + 1;
      en = {pbus_en[1], pbus_en[0], hbus_en};
      if (rst_n) begin
         for (int i = 0; i < 3; i++) begin
            if (en[i]) begin
               gap_last[i] = cyc - last_hi[i];
               last_hi[i]  = cyc;
               hi_cnt[i]   = hi_cnt[i] + 1;
            end
         end
         if ((pbus_en[0] || pbus_en[1]) && !hbus_en) pb_viol = pb_viol + 1;
      end
   end

   always @(posedge clk) begin
      if (!done && cyc > WD_LIMIT) begin
         n_tests = n_tests + 1;
         n_fail  = n_fail + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests = n_tests + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_field(input int addr, input int data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_waddr = 2'(addr);
      cfg_wdata = 4'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic read_field(input int addr, output int fld, output int rat);
      cfg_raddr = 2'(addr);
      #1;
      fld = int'(cfg_rfield);
      rat = int'(cfg_rratio);
   endtask

   task automatic wait_pulse(input int idx, output int gap);
      int c;
      c = hi_cnt[idx];
      while (hi_cnt[idx] == c) @(posedge clk);
      gap = gap_last[idx];
   endtask

   task automatic settled_gap(input int idx, output int gap);
      int g;
      wait_pulse(idx, g);
      wait_pulse(idx, g);
      wait_pulse(idx, gap);
   endtask

   initial begin
      int fld, rat, g, g2;
      int base_pb1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, all enables held high
      for (int a = 0; a < 3; a++) begin
         read_field(a, fld, rat);
         check("R1 reset field", fld, 0);
         check("R1 reset ratio", rat, 1);
      end
      begin
         int highs;
         highs = 0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (hbus_en && pbus_en == 2'b11) highs++;
         end
         check("R1 R6 enables held high at divide by 1", highs, 5);
      end

      // R2 R3 R4 R5 R8: table of codes and expected periods
      for (int v = 0; v < NVEC; v++) begin
         write_field(0, VEC[v][0]);
         write_field(1, VEC[v][1]);
         write_field(2, VEC[v][2]);
         for (int a = 0; a < 3; a++) begin
            read_field(a, fld, rat);
            check("R8 readback code", fld, VEC[v][a]);
            check("R8 readback overall ratio", rat, VEC[v][3 + a]);
         end
         settled_gap(0, g);
         check("R2 R6 hbus period", g, VEC[v][3]);
         settled_gap(1, g);
         check("R3 R4 pbus0 period", g, VEC[v][4]);
         settled_gap(2, g);
         check("R3 R4 R5 pbus1 period", g, VEC[v][5]);
      end

      // R5: changing pbus0 leaves pbus1 untouched (hbus /8 from last vector)
      read_field(2, base_pb1, rat);
      write_field(1, 7);
      read_field(2, fld, rat);
      check("R5 pb1 code after pb0 write", fld, base_pb1);
      settled_gap(1, g);
      check("R5 pbus0 new period", g, 128);
      settled_gap(2, g);
      check("R5 pbus1 period unchanged", g, 32);

      // R9: address 3 writes nothing and reads zero
      write_field(3, 15);
      read_field(0, fld, rat);
      check("R9 hs code after addr3 write", fld, 10);
      read_field(1, fld, rat);
      check("R9 pb0 code after addr3 write", fld, 7);
      read_field(2, fld, rat);
      check("R9 pb1 code after addr3 write", fld, 5);
      read_field(3, fld, rat);
      check("R9 addr3 field readback", fld, 0);
      check("R9 addr3 ratio readback", rat, 0);
      settled_gap(0, g);
      check("R9 hbus period after addr3 write", g, 8);

      // R7 R8: write during a long period; period completes at old length
      write_field(1, 0);
      write_field(2, 0);
      write_field(0, 15);
      settled_gap(0, g);
      check("R2 hbus period /512", g, 512);
      write_field(0, 8);
      read_field(0, fld, rat);
      check("R8 pending code readback", fld, 8);
      check("R8 pending ratio readback", rat, 2);
      wait_pulse(0, g);
      check("R7 period in progress keeps old length", g, 512);
      wait_pulse(0, g2);
      check("R7 new period after terminal count", g2, 2);

      // R7: short-to-shorter change in the middle of a period
      write_field(0, 9);
      settled_gap(0, g);
      write_field(0, 8);
      wait_pulse(0, g);
      check("R7 /4 period not shortened", g, 4);
      wait_pulse(0, g);
      check("R7 /2 period after change", g, 2);

      // R4: peripheral enable never without high-speed enable
      check("R4 pbus pulses outside hbus", pb_viol, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule